// File: doc/BRIEF.md
# Display Scanline Timing and Status Unit

The unit paces a 240x160 display. Each line has a draw phase followed by a horizontal blank. A line counter advances once per line and covers visible lines and then vertical blank lines. The unit keeps the blanking and coincidence flags that software reads. It also emits single-cycle interrupt requests and DMA start strobes when the phase or the line changes.

Software programs a 16-bit status/control word, which holds the interrupt enables and a trigger line, and reads it back together with the live flags. The current line number is a read-only output. A clock enable input pauses the whole unit without losing its state. All phase and frame lengths are parameters. The defaults are 960 draw cycles, 272 blank cycles, 228 lines and 160 visible lines.

Top module: `scan_timer_unit`

## Requirements
- R1: While `rst_ni` is low, and after its release before any enabled cycle, `stat_o[2:0]`, `stat_o[15:3]` and `line_o` read zero and no pulse output is high.
- R2: The draw phase lasts DRAW_CYC enabled cycles. The horizontal blank flag `stat_o[1]` then reads 1 for HB_CYC enabled cycles and clears in the cycle the line counter advances.
- R3: `line_o` advances by one at the end of each horizontal blank and wraps from LINES-1 to 0.
- R4: The vertical blank flag `stat_o[0]` sets when the line becomes VIS_LINES. It clears when the line becomes LINES-1, and it stays 0 at the wrap to line 0.
- R5: At each line advance, `stat_o[2]` is loaded with (new line == trigger `stat_o[15:8]`). `irq_match_o` pulses at that advance on a match only if enable bit 5 is 1.
- R6: `irq_hb_o` pulses when each horizontal blank starts, on visible and blank lines alike, if enable bit 4 is 1.
- R7: `irq_vb_o` pulses when the line becomes VIS_LINES, if enable bit 3 is 1.
- R8: `dma_hb_o` pulses at every horizontal blank start and `dma_vb_o` pulses when the line becomes VIS_LINES. Both pulse whatever the enables are.
- R9: A write (`wr_en_i`) loads bits 5:3 (enables) and 15:8 (trigger) from `wr_data_i`. Bits 2:0 of the data are ignored, and `stat_o[7:6]` always reads 0.
- R10: While `en_i` is low, the line, the phase position and all flags hold, and no pulse is issued.
- R11: Every interrupt and DMA output is high for one cycle only. It rises in the cycle its flag or the line changes, which is one clock after the enabled edge that ends the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Cycle enable; low pauses the unit |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word data (bits 5:3 enables, 15:8 trigger line) |
| stat_o | output | 16 | Bit0 vblank, bit1 hblank, bit2 coincidence, bits5:3 enables, 15:8 trigger |
| line_o | output | 8 | Current line number |
| irq_hb_o | output | 1 | Horizontal blank interrupt request pulse |
| irq_vb_o | output | 1 | Vertical blank interrupt request pulse |
| irq_match_o | output | 1 | Line match interrupt request pulse |
| dma_hb_o | output | 1 | Horizontal blank DMA start pulse |
| dma_vb_o | output | 1 | Vertical blank DMA start pulse |

## Verification
A position counter that is off by one moves the rise of the horizontal blank flag and of its pulses. That error shows within the first line, so each line is checked cycle by cycle. A wrong line counter or a wrong wrap, or a vertical blank flag that clears at line 0 instead of the last line, shows only once a whole frame has run. The bench therefore runs the unit with reduced parameters for several frames. A trigger compared at the wrong edge, or a coincidence flag updated between advances, changes `stat_o[2]` or the match pulse count in the first frame after the trigger is written.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int LINE_W = 8;

  typedef struct packed {
    logic [LINE_W-1:0] trig;
    logic [1:0]        rsvd;
    logic              en_match;
    logic              en_hb;
    logic              en_vb;
    logic              coin;
    logic              hb;
    logic              vb;
  } stat_t;
endpackage

// File: rtl/scan_hcount.sv
module scan_hcount #(
  parameter int DRAW_CYC = 960,
  parameter int HB_CYC   = 272
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic hb_start_o,
  output logic line_end_o
);
  localparam int LINE_CYC = DRAW_CYC + HB_CYC;
  localparam int DW = $clog2(LINE_CYC);
  localparam logic [DW-1:0] LAST_DRAW = DW'(DRAW_CYC - 1);
  localparam logic [DW-1:0] LAST_DOT  = DW'(LINE_CYC - 1);

  logic [DW-1:0] dot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dot_q <= '0;
    else if (en_i)  dot_q <= (dot_q == LAST_DOT) ? '0 : dot_q + 1'b1;
  end

  assign hb_start_o = en_i && (dot_q == LAST_DRAW);
  assign line_end_o = en_i && (dot_q == LAST_DOT);

  p_dot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= LAST_DOT);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dot_q));
endmodule

// File: rtl/scan_vcount.sv
module scan_vcount #(
  parameter int LINES     = 228,
  parameter int VIS_LINES = 160
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      adv_i,
  output logic [scan_pkg::LINE_W-1:0] line_o,
  output logic [scan_pkg::LINE_W-1:0] nxt_line_o,
  output logic                      vb_set_o,
  output logic                      vb_clr_o
);
  localparam int LW = scan_pkg::LINE_W;
  localparam logic [LW-1:0] LAST_LN = LW'(LINES - 1);
  localparam logic [LW-1:0] VIS_LN  = LW'(VIS_LINES);

  logic [LW-1:0] line_q;

  assign nxt_line_o = (line_q == LAST_LN) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= '0;
    else if (adv_i)  line_q <= nxt_line_o;
  end

  assign line_o   = line_q;
  assign vb_set_o = adv_i && (nxt_line_o == VIS_LN);
  assign vb_clr_o = adv_i && (nxt_line_o == LAST_LN);

  p_line_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= LAST_LN);
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && line_q == LAST_LN |=> line_q == '0);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(line_q));
endmodule

// File: rtl/scan_status.sv
module scan_status (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [15:0]                 wr_data_i,
  input  logic                        hb_start_i,
  input  logic                        adv_i,
  input  logic [scan_pkg::LINE_W-1:0] nxt_line_i,
  input  logic                        vb_set_i,
  input  logic                        vb_clr_i,
  output logic [15:0]                 stat_o,
  output logic                        irq_hb_o,
  output logic                        irq_vb_o,
  output logic                        irq_match_o,
  output logic                        dma_hb_o,
  output logic                        dma_vb_o
);
  import scan_pkg::*;

  logic              vb_q, hb_q, coin_q;
  logic [2:0]        ien_q;
  logic [LINE_W-1:0] trig_q;
  logic              hit;
  stat_t             st;
  logic              unused_wr;

  assign unused_wr = ^{wr_data_i[7:6], wr_data_i[2:0]};
  assign hit       = (nxt_line_i == trig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_q <= 1'b0; hb_q <= 1'b0; coin_q <= 1'b0;
      ien_q <= '0; trig_q <= '0;
      irq_hb_o <= 1'b0; irq_vb_o <= 1'b0; irq_match_o <= 1'b0;
      dma_hb_o <= 1'b0; dma_vb_o <= 1'b0;
    end else begin
      if (adv_i)           hb_q <= 1'b0;
      else if (hb_start_i) hb_q <= 1'b1;
      if (vb_set_i)        vb_q <= 1'b1;
      else if (vb_clr_i)   vb_q <= 1'b0;
      if (adv_i)           coin_q <= hit;
      if (wr_en_i) begin
        ien_q  <= wr_data_i[5:3];
        trig_q <= wr_data_i[15:8];
      end
      irq_hb_o    <= hb_start_i && ien_q[1];
      irq_vb_o    <= vb_set_i && ien_q[0];
      irq_match_o <= adv_i && hit && ien_q[2];
      dma_hb_o    <= hb_start_i;
      dma_vb_o    <= vb_set_i;
    end
  end

  always_comb begin
    st          = '0;
    st.trig     = trig_q;
    st.en_match = ien_q[2];
    st.en_hb    = ien_q[1];
    st.en_vb    = ien_q[0];
    st.coin     = coin_q;
    st.hb       = hb_q;
    st.vb       = vb_q;
  end
  assign stat_o = st;

  p_hb_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hb_o |=> !dma_hb_o);
  p_hb_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hb_o |-> hb_q);
  p_vb_dma_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_vb_o |-> vb_q && $rose(vb_q));
  p_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_match_o |-> coin_q);
  p_coin_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(coin_q));
endmodule

// File: rtl/scan_timer_unit.sv
module scan_timer_unit #(
  parameter int DRAW_CYC  = 960,
  parameter int HB_CYC    = 272,
  parameter int LINES     = 228,
  parameter int VIS_LINES = 160
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] stat_o,
  output logic [7:0]  line_o,
  output logic        irq_hb_o,
  output logic        irq_vb_o,
  output logic        irq_match_o,
  output logic        dma_hb_o,
  output logic        dma_vb_o
);
  logic       hb_start, line_end, vb_set, vb_clr;
  logic [7:0] nxt_line;

  scan_hcount #(.DRAW_CYC(DRAW_CYC), .HB_CYC(HB_CYC)) u_h (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .hb_start_o(hb_start), .line_end_o(line_end)
  );

  scan_vcount #(.LINES(LINES), .VIS_LINES(VIS_LINES)) u_v (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(line_end),
    .line_o(line_o), .nxt_line_o(nxt_line),
    .vb_set_o(vb_set), .vb_clr_o(vb_clr)
  );

  scan_status u_s (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .hb_start_i(hb_start), .adv_i(line_end), .nxt_line_i(nxt_line),
    .vb_set_i(vb_set), .vb_clr_i(vb_clr),
    .stat_o(stat_o),
    .irq_hb_o(irq_hb_o), .irq_vb_o(irq_vb_o), .irq_match_o(irq_match_o),
    .dma_hb_o(dma_hb_o), .dma_vb_o(dma_vb_o)
  );
endmodule

// File: tb/sim_scan_timer_unit.sv
module sim_scan_timer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DRAW = 12;
  localparam int HB   = 6;
  localparam int LN   = 12;
  localparam int VIS  = 8;
  localparam int LC   = DRAW + HB;

  logic clk = 0, rst_ni = 0, en = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] stat;
  logic [7:0]  line;
  logic irq_hb, irq_vb, irq_match, dma_hb, dma_vb;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_timer_unit #(.DRAW_CYC(DRAW), .HB_CYC(HB), .LINES(LN), .VIS_LINES(VIS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .stat_o(stat), .line_o(line), .irq_hb_o(irq_hb), .irq_vb_o(irq_vb),
    .irq_match_o(irq_match), .dma_hb_o(dma_hb), .dma_vb_o(dma_vb)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int n = 0;
  bit m_vb = 0, m_coin = 0;
  logic [2:0] m_en = '0;
  logic [7:0] m_trig = '0;
  int c_hbirq, c_vbirq, c_match, c_dmahb, c_dmavb;

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  task automatic tick();
    bit stp, adv;
    int pos, ln;
    @(posedge clk);
    stp = en;
    if (stp) n++;
    pos = n % LC;
    ln  = (n / LC) % LN;
    adv = stp && pos == 0;
    @(negedge clk);
    chk("R2 hblank flag", stat[1], pos >= DRAW);
    chk("R3 line", line, ln);
    chk("R6 irq_hb", irq_hb, stp && pos == DRAW && m_en[1]);
    chk("R7 irq_vb", irq_vb, adv && ln == VIS && m_en[0]);
    chk("R5 irq_match", irq_match, adv && ln == m_trig && m_en[2]);
    chk("R8 dma_hb", dma_hb, stp && pos == DRAW);
    chk("R8 dma_vb", dma_vb, adv && ln == VIS);
    if (adv) m_coin = (ln == m_trig);
    if (adv && ln == VIS) m_vb = 1;
    if (adv && ln == LN-1) m_vb = 0;
    if (wr_en) begin m_en = wr_data[5:3]; m_trig = wr_data[15:8]; end
    chk("R4 vblank flag", stat[0], m_vb);
    chk("R5 coincidence", stat[2], m_coin);
    chk("R9 control bits", stat[15:3], {m_trig, 2'b00, m_en});
    c_hbirq += irq_hb; c_vbirq += irq_vb; c_match += irq_match;
    c_dmahb += dma_hb; c_dmavb += dma_vb;
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic clr_counts();
    c_hbirq = 0; c_vbirq = 0; c_match = 0; c_dmahb = 0; c_dmavb = 0;
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic t_reset();
    rst_ni = 0; en = 0;
    repeat (2) @(negedge clk);
    chk("R1 stat in reset", stat, 0);
    chk("R1 line in reset", line, 0);
    chk("R1 pulses in reset", {irq_hb, irq_vb, irq_match, dma_hb, dma_vb}, 0);
    rst_ni = 1;
    n = 0; m_vb = 0; m_coin = 0; m_en = '0; m_trig = '0;
    tick();
    chk("R1 stat after release", stat, 0);
  endtask

  task automatic t_free_run();
    en = 1;
    clr_counts();
    run(2 * LN * LC);
    chk("R8 dma_hb count over 2 frames", c_dmahb, 2 * LN);
    chk("R8 dma_vb count over 2 frames", c_dmavb, 2);
    chk("R6 no irq_hb when disabled", c_hbirq, 0);
  endtask

  task automatic t_ctrl_write();
    wr(16'h05FF);
    chk("R9 reserved bits read zero", stat[7:6], 0);
    chk("R9 trigger field", stat[15:8], 5);
    chk("R9 enables loaded", stat[5:3], 7);
  endtask

  task automatic t_irqs();
    clr_counts();
    run(LN * LC);
    chk("R6 R11 irq_hb one pulse per line", c_hbirq, LN);
    chk("R7 irq_vb one per frame", c_vbirq, 1);
    chk("R5 irq_match one per frame", c_match, 1);
  endtask

  task automatic t_match_off();
    wr(16'h0318);
    clr_counts();
    run(LN * LC);
    chk("R5 no match irq when disabled", c_match, 0);
    chk("R6 irq_hb still on", c_hbirq, LN);
    wr(16'h0B20);
    clr_counts();
    run(LN * LC);
    chk("R5 match on line LINES-1", c_match, 1);
    chk("R7 irq_vb disabled", c_vbirq, 0);
  endtask

  task automatic t_gate();
    logic [15:0] s0;
    logic [7:0]  l0;
    run(LC + DRAW - 1);
    en = 0;
    tick();
    s0 = stat; l0 = line;
    clr_counts();
    run(40);
    chk("R10 line held", line, l0);
    chk("R10 status held", stat, s0);
    chk("R10 no pulses", c_hbirq + c_vbirq + c_match + c_dmahb + c_dmavb, 0);
    en = 1;
    run(3 * LC);
  endtask

  task automatic t_single();
    int prev, dbl;
    prev = 0; dbl = 0;
    for (int i = 0; i < LN * LC; i++) begin
      tick();
      if (prev == 1 && dma_hb == 1) dbl++;
      prev = dma_hb;
    end
    chk("R11 dma_hb never two cycles", dbl, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_free_run();
    t_ctrl_write();
    t_irqs();
    t_match_off();
    t_gate();
    t_single();
    t_reset();
    en = 1;
    run(LN * LC + 5);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule